// File: doc/BRIEF.md
# Four/Five-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address by walking radix page tables held in memory. It handles one translation at a time. A request carries the virtual address and a mode flag. When the flag is clear, the walk uses four table levels over a 48-bit virtual space. When it is set, an extra top level widens the space to 57 bits. The walker reads each 8-byte entry through a simple request/acknowledge memory port. If an entry's accessed flag is still clear, the walker writes the entry back with the flag set. At the end it returns the physical frame, the page size, the combined permissions and a fault code.

The root table base and an address-wrap mask are inputs from the surrounding core. The mask is applied to every entry address. Both inputs must be held steady while a walk is in progress. A request is taken only while `req_ready` is high. The result appears during the single cycle in which `rsp_valid` is high.

Top module: `pt_walker`

## Requirements
- R1: The canonical check depends on the mode. In five-level mode (`req_mode5`=1), virtual bits 63:56 must be all zeros or all ones. In four-level mode, bits 63:47 must be. Any other address completes with `rsp_fault`=1 (general protection), and no memory access is made.
- R2: A five-level walk starts at the top level, indexed by virtual bits 56:48. A four-level walk starts at the level indexed by bits 47:39. The lower levels use bits 38:30, 29:21 and 20:12, and each index picks one of 512 entries.
- R3: The first entry address is `root_base` with bits 11:0 cleared, plus the index times 8. Every entry address, for reads and for write-backs alike, is ANDed with `a20_mask`.
- R4: The next table base is bits 51:12 of the current entry, with every other bit cleared.
- R5: An entry whose bit 0 (present) is clear ends the walk with `rsp_fault`=2 (not present).
- R6: In five-level mode only, a top-level entry that has any of bits 62:52 set, or bit 7 (page size) set, ends the walk with `rsp_fault`=3 (reserved bit). The same bits at lower levels do not fault.
- R7: A present entry whose bit 5 (accessed) is clear is written back to its own address with bit 5 set. This write happens before the next read or the response.
- R8: `rsp_perm` is {execute, user, write} in bits 2,1,0. It starts at all ones and is ANDed at each present entry with {~bit63, bit2, bit1}.
- R9: Bit 7 set at the level indexed by bits 38:30 ends the walk with a 1 GiB page (`rsp_size`=2, paddr = entry[51:30] joined to va[29:0]). Bit 7 set at the level indexed by bits 29:21 gives a 2 MiB page (`rsp_size`=1, entry[51:21] joined to va[20:0]). Otherwise the last level gives a 4 KiB page (`rsp_size`=0, entry[51:12] joined to va[11:0]).
- R10: `rsp_valid` is a one-cycle pulse. `req_ready` is high only when idle. A faulting walk reports `rsp_paddr`=0, `rsp_size`=0 and `rsp_perm`=0.
- R11: `mem_req` stays high, with the same address, direction and write data, until a cycle in which `mem_ack` is high. There is no memory traffic while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 64 | Virtual address |
| req_mode5 | input | 1 | 1 = five-level, 0 = four-level |
| root_base | input | 64 | Root table base |
| a20_mask | input | 64 | AND mask for entry addresses |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write-back, 0 = read |
| mem_addr | output | 64 | Entry address |
| mem_wdata | output | 64 | Write-back data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 64 | Read data, valid with mem_ack |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | PA_W | Physical address |
| rsp_size | output | 2 | 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| rsp_fault | output | 2 | 0 none, 1 GP, 2 not present, 3 reserved |
| rsp_perm | output | 3 | {execute, user, write} |

## Verification
The bench builds the walker with its default 52-bit physical width. At that width the reserved field of a top-level entry is exactly bits 62:52, and frames can carry high address bits that a narrower walker would truncate. A behavioural model in the bench predicts the exact sequence of reads and write-backs, as well as the result of each walk. The memory responder delays its acknowledges by 0 to 2 cycles, so the request-hold rule is exercised. The cases cover both modes, all three page sizes, all three fault kinds, mask-wrapped roots and repeated walks after accessed bits have been set.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int PA_W = 52
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [63:0]     req_vaddr,
  input  logic            req_mode5,
  input  logic [63:0]     root_base,
  input  logic [63:0]     a20_mask,
  output logic            mem_req,
  output logic            mem_we,
  output logic [63:0]     mem_addr,
  output logic [63:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic [63:0]     mem_rdata,
  output logic            rsp_valid,
  output logic [PA_W-1:0] rsp_paddr,
  output logic [1:0]      rsp_size,
  output logic [1:0]      rsp_fault,
  output logic [2:0]      rsp_perm
);
  localparam logic [63:0] FRAME_MASK = ((64'd1 << PA_W) - 64'd1) & ~64'hFFF;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_READ, S_EVAL, S_SETA, S_NEXT, S_DONE} st_t;
  st_t st;

  logic [63:0]     va, base, ent;
  logic            m5;
  logic [2:0]      lvl, acc;
  logic [PA_W-1:0] paddr;
  logic [1:0]      size, fault;

  wire [8:0] idx     = va[12 + 9*lvl +: 9];
  wire canon5        = (&va[63:56]) | ~(|va[63:56]);
  wire canon4        = (&va[63:47]) | ~(|va[63:47]);
  wire rsvd_top      = (|ent[62:PA_W]) | ent[7];
  wire leaf          = (lvl == 3'd0) || ((lvl == 3'd1 || lvl == 3'd2) && ent[7]);

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_DONE);
  assign mem_req   = (st == S_READ) || (st == S_SETA);
  assign mem_we    = (st == S_SETA);
  assign mem_addr  = {base[63:12], idx, 3'b000} & a20_mask;
  assign mem_wdata = ent | 64'h20;
  assign rsp_paddr = paddr;
  assign rsp_size  = size;
  assign rsp_fault = fault;
  assign rsp_perm  = acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      va    <= '0;
      m5    <= 1'b0;
      base  <= '0;
      ent   <= '0;
      lvl   <= '0;
      acc   <= '0;
      paddr <= '0;
      size  <= '0;
      fault <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va <= req_vaddr;
          m5 <= req_mode5;
          st <= S_CHECK;
        end
        S_CHECK: begin
          acc   <= 3'b111;
          paddr <= '0;
          size  <= '0;
          fault <= '0;
          if (m5 ? canon5 : canon4) begin
            lvl  <= m5 ? 3'd4 : 3'd3;
            base <= root_base & ~64'hFFF;
            st   <= S_READ;
          end else begin
            acc   <= '0;
            fault <= 2'd1;
            st    <= S_DONE;
          end
        end
        S_READ: if (mem_ack) begin
          ent <= mem_rdata;
          st  <= S_EVAL;
        end
        S_EVAL: begin
          if (!ent[0]) begin
            fault <= 2'd2;
            acc   <= '0;
            st    <= S_DONE;
          end else if (lvl == 3'd4 && rsvd_top) begin
            fault <= 2'd3;
            acc   <= '0;
            st    <= S_DONE;
          end else begin
            acc <= acc & {~ent[63], ent[2], ent[1]};
            st  <= ent[5] ? S_NEXT : S_SETA;
          end
        end
        S_SETA: if (mem_ack) st <= S_NEXT;
        S_NEXT: begin
          if (leaf) begin
            size <= lvl[1:0];
            case (lvl)
              3'd2:    paddr <= {ent[PA_W-1:30], va[29:0]};
              3'd1:    paddr <= {ent[PA_W-1:21], va[20:0]};
              default: paddr <= {ent[PA_W-1:12], va[11:0]};
            endcase
            st <= S_DONE;
          end else begin
            base <= ent & FRAME_MASK;
            lvl  <= lvl - 3'd1;
            st   <= S_READ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 52
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            mem_req,
  input logic            mem_we,
  input logic [63:0]     mem_addr,
  input logic [63:0]     mem_wdata,
  input logic            mem_ack,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_size,
  input logic [1:0]      rsp_fault,
  input logic [2:0]      rsp_perm
);
  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r10_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0 && rsp_perm == 3'd0 && rsp_size == 2'd0));

  a_r9_size_code: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_size != 2'd3);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready || rsp_valid) |-> !mem_req);

  a_r7_wb_sets_a: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[5] && mem_wdata[0]));
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (.*);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_mode5;
  logic [63:0] req_vaddr, root_base, a20_mask;
  logic mem_req, mem_we, mem_ack;
  logic [63:0] mem_addr, mem_wdata, mem_rdata;
  logic rsp_valid;
  logic [51:0] rsp_paddr;
  logic [1:0] rsp_size, rsp_fault;
  logic [2:0] rsp_perm;

  pt_walker u_dut (.*);

  localparam logic [63:0] P = 64'h1, W = 64'h2, U = 64'h4, A = 64'h20, PS = 64'h80, NX = 64'h1 << 63;

  logic [63:0] mem [logic [63:0]];
  logic [128:0] expq[$];
  logic [51:0] e_paddr;
  logic [1:0] e_size, e_fault;
  logic [2:0] e_perm;
  bit pend = 0;
  int checks = 0, errors = 0, dly = 0, dseq = 0, cyc = 0;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic void model(logic [63:0] va, bit m5, logic [63:0] root, logic [63:0] msk);
    int lv;
    logic [63:0] base, addr, e;
    logic [2:0] acc;
    bit canon;
    e_paddr = 0; e_size = 0; e_fault = 0; e_perm = 0;
    canon = m5 ? (va[63:56] == 8'h00 || va[63:56] == 8'hFF)
               : (va[63:47] == 17'h0 || va[63:47] == 17'h1FFFF);
    if (!canon) begin e_fault = 1; return; end
    lv = m5 ? 4 : 3;
    base = root & ~64'hFFF;
    acc = 3'b111;
    while (1) begin
      addr = (base + (((va >> (12 + 9*lv)) & 64'h1FF) * 8)) & msk;
      e = rd(addr);
      expq.push_back({1'b0, addr, 64'h0});
      if (e[0] == 1'b0) begin e_fault = 2; return; end
      if (lv == 4 && (e[62:52] != 0 || e[7])) begin e_fault = 3; return; end
      acc = acc & {~e[63], e[2], e[1]};
      if (e[5] == 1'b0) expq.push_back({1'b1, addr, e | 64'h20});
      if (lv == 2 && e[7]) begin e_size = 2; e_paddr = {e[51:30], va[29:0]}; e_perm = acc; return; end
      if (lv == 1 && e[7]) begin e_size = 1; e_paddr = {e[51:21], va[20:0]}; e_perm = acc; return; end
      if (lv == 0) begin e_size = 0; e_paddr = {e[51:12], va[11:0]}; e_perm = acc; return; end
      base = e & 64'h000F_FFFF_FFFF_F000;
      lv--;
    end
  endfunction

  task automatic put(logic [63:0] tbl, logic [63:0] va, int lv, logic [63:0] val);
    mem[tbl + (((va >> (12 + 9*lv)) & 64'h1FF) * 8)] = val;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (dly > 0) dly--;
      else begin
        if (expq.size() == 0) chk(0, "R11", "unexpected access", mem_addr, 64'h0);
        else begin
          logic [128:0] op;
          op = expq.pop_front();
          chk(mem_we == op[128], "R7", "access kind", {63'h0, mem_we}, {63'h0, op[128]});
          chk(mem_addr == op[127:64], "R3", "entry address", mem_addr, op[127:64]);
          if (mem_we) chk(mem_wdata == op[63:0], "R7", "write-back data", mem_wdata, op[63:0]);
        end
        mem_rdata = rd(mem_addr);
        if (mem_we) mem[mem_addr] = mem_wdata;
        mem_ack = 1'b1;
        dly = dseq % 3;
        dseq++;
      end
    end
    if (rsp_valid) begin
      if (!pend) chk(0, "R10", "unexpected response", 64'h1, 64'h0);
      else begin
        chk(rsp_fault == e_fault, "R10", "fault code", {62'h0, rsp_fault}, {62'h0, e_fault});
        chk(rsp_paddr == e_paddr, "R9", "physical address", {12'h0, rsp_paddr}, {12'h0, e_paddr});
        chk(rsp_size == e_size, "R9", "page size", {62'h0, rsp_size}, {62'h0, e_size});
        chk(rsp_perm == e_perm, "R8", "permissions", {61'h0, rsp_perm}, {61'h0, e_perm});
        chk(expq.size() == 0, "R2", "accesses left over", expq.size(), 64'h0);
        pend = 0;
      end
    end
  end

  task automatic walk(logic [63:0] va, bit m5, logic [63:0] root, logic [63:0] msk);
    while (!req_ready) @(negedge clk);
    root_base = root; a20_mask = msk;
    model(va, m5, root, msk);
    pend = 1;
    req_vaddr = va; req_mode5 = m5; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R10", "ready after accept", {63'h0, req_ready}, 64'h0);
    while (pend) @(negedge clk);
  endtask

  initial begin
    while (cyc < 100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] VA5 = 64'h0012_3456_789A_BCDE;
  localparam logic [63:0] VA2M = 64'hFFFF_8012_3456_7890;
  localparam logic [63:0] VA1G = 64'h0000_7ABC_DEF1_2345;

  initial begin
    rst_n = 0; req_valid = 0; req_vaddr = 0; req_mode5 = 0;
    root_base = 0; a20_mask = ONES; mem_ack = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req, "R10", "reset state",
        {61'h0, req_ready, rsp_valid, mem_req}, 64'h4);

    // R2 R4 R8 R9: five-level 4 KiB walk, accessed bits already set
    put(64'h1000, VA5, 4, 64'h2000 | P | W | U | A);
    put(64'h2000, VA5, 3, 64'h3000 | P | W | U | A);
    put(64'h3000, VA5, 2, 64'h4000 | P | W | A);
    put(64'h4000, VA5, 1, 64'h5000 | P | W | U | A);
    put(64'h5000, VA5, 0, 64'h000A_BCDE_F000 | P | U | A);
    walk(VA5, 1, 64'h1000, ONES);

    // R7: clear accessed bits at two levels, expect write-backs, then none
    put(64'h2000, VA5, 3, 64'h3000 | P | W | U);
    put(64'h5000, VA5, 0, 64'h000A_BCDE_F000 | P | U);
    walk(VA5, 1, 64'h1000, ONES);
    walk(VA5, 1, 64'h1000, ONES);

    // R3: wrap mask clears bit 20 of the root
    walk(VA5, 1, 64'h0010_1000, ~(64'h1 << 20));

    // R9 R8: four-level 2 MiB with execute-disable above
    put(64'h10000, VA2M, 3, 64'h11000 | P | W | U | A | NX);
    put(64'h11000, VA2M, 2, 64'h12000 | P | W | U | A);
    put(64'h12000, VA2M, 1, 64'h00AB_CDE0_0000 | P | W | U | A | PS);
    walk(VA2M, 0, 64'h10000, ONES);

    // R9 R7: four-level 1 GiB with a write-back above
    put(64'h20000, VA1G, 3, 64'h21000 | P | W | U);
    put(64'h21000, VA1G, 2, 64'h000F_4000_0000 | P | W | U | A | PS);
    walk(VA1G, 0, 64'h20000, ONES);

    // R1 R5: canonical checks per mode
    walk(64'h0000_8000_0000_0000, 0, 64'h1000, ONES);
    walk(64'h0000_8000_0000_0000, 1, 64'h1000, ONES);
    walk(64'h0100_0000_0000_0000, 1, 64'h1000, ONES);
    walk(64'hFF00_0000_0000_0000, 1, 64'h1000, ONES);

    // R6: reserved and page-size bits in a top-level entry
    put(64'h30000, 64'h00AA_0000_0000_0000, 4, 64'h31000 | P | A | (64'h1 << 60));
    walk(64'h00AA_0000_0000_0000, 1, 64'h30000, ONES);
    put(64'h30000, 64'h00AB_0000_0000_0000, 4, 64'h31000 | P | A | PS);
    walk(64'h00AB_0000_0000_0000, 1, 64'h30000, ONES);

    // R6: same reserved bit below the top level is not a fault
    put(64'h40000, 64'h0000_1000_0000_0000, 3, (64'h1 << 60) | 64'h41000 | P | A | W | U);
    put(64'h41000, 64'h0000_1000_0000_0000, 2, 64'h4000_0000 | P | A | PS | W | U);
    walk(64'h0000_1000_0000_0000, 0, 64'h40000, ONES);

    // R5: missing entry at the third level
    walk(64'h0000_1000_4000_0000, 0, 64'h40000, ONES);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule